// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a write-through cache and the next memory level. The CPU hands it a store as a word address and a data word. The store is acknowledged in the cycle it is offered, and the memory write happens later in the background. Each buffer entry covers one four-word block and keeps a valid bit for every word lane. A store whose block is already waiting in the buffer joins that entry, so the block goes to memory as one multi-word write with a lane mask. It does not go as several single-word writes.

A read miss from the cache is handled as a one-cycle request. Before the read is placed on the shared memory port, its block is compared against every buffered entry. If no entry overlaps, the read goes to memory ahead of any pending drains. If an entry does overlap, drains continue in allocation order until no buffered entry holds that block. The read then goes out, so it always returns the newest stored data. The memory port carries one command at a time: either a masked block write or a single-word read.

Top module: `merge_wbuf`

## Requirements
- R1: A store is accepted on the rising edge where `st_valid` and `st_ready` are both high. `st_ready` is high whenever fewer than four entries are in use, or when a mergeable entry for the store's block exists.
- R2: When all four entries are in use and no mergeable entry matches the store's block, `st_ready` is low and the store is held off.
- R3: A store to a block held in an entry that is not being drained is merged into that entry. It sets that word's lane bit, and a later store to the same word replaces the earlier data. The whole entry then reaches memory as a single write.
- R4: The entry currently offered to memory as a drain accepts no merges. A store to its block takes a fresh entry, which is written separately afterwards.
- R5: Entries drain in the order they were first allocated. A drain drives `mem_write`=1 and `mem_addr` = block base, which is the word address with its two low bits zero. Lane i sits in `mem_wdata[32*i+31:32*i]`, and `mem_wmask` bit i is set exactly for the lanes that were stored.
- R6: A pending read whose block matches no buffered entry is issued with `mem_write`=0 as soon as the current memory command completes. It goes ahead of any entries still waiting to drain.
- R7: A pending read whose block matches a buffered entry is not issued until every such entry has been drained. The returned word equals the most recent store to that address.
- R8: Once `mem_valid` is raised, it stays high with `mem_write` and `mem_addr` unchanged until the cycle in which `mem_ready` is high.
- R9: Only one read is handled at a time, and `rd_req` is ignored while a read is pending. `rd_rsp_valid` pulses for one cycle, on the cycle after `mem_rvalid`, and `rd_rsp_data` carries the word from `mem_rdata`.
- R10: After reset the buffer is empty, `st_ready` is high, and `mem_valid` and `rd_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | 12 | Store word address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store can be taken this cycle |
| rd_req | input | 1 | One-cycle read-miss request |
| rd_addr | input | 12 | Read word address, sampled with `rd_req` |
| rd_rsp_valid | output | 1 | Read data valid pulse |
| rd_rsp_data | output | 32 | Read data |
| mem_valid | output | 1 | Memory command valid |
| mem_write | output | 1 | 1 = masked block write, 0 = word read |
| mem_addr | output | 12 | Block base (write) or word address (read) |
| mem_wdata | output | 128 | Four write lanes, lane 0 in the low bits |
| mem_wmask | output | 4 | Lanes to write |
| mem_ready | input | 1 | Memory takes the command this cycle |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned read word |

## Verification
A lost lane bit or a merge into the entry being drained shows up at the next drain of that block: the write's mask or data differs from what the stores imply, or the block appears too many or too few times. A broken allocation pointer reorders the block addresses of later drains, or stalls stores while the buffer still has free space. A weak conflict check lets a read through ahead of an older write to the same word, and the first response from that address carries stale data. A wrong priority choice changes the order of read and write commands on the memory port within a few cycles of memory becoming ready.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LANES  = 4;
    localparam int DEPTH  = 4;
    localparam int LANE_W = $clog2(LANES);
    localparam int BLK_W  = ADDR_W - LANE_W;
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                          live;
        logic [BLK_W-1:0]              blk;
        logic [LANES-1:0]              mask;
        logic [LANES-1:0][DATA_W-1:0]  data;
    } wb_entry_t;

    typedef enum logic [1:0] {
        ARB_IDLE,
        ARB_WR,
        ARB_RD,
        ARB_RWAIT
    } arb_state_t;

    function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:LANE_W];
    endfunction

    function automatic logic [LANE_W-1:0] lane_of(input logic [ADDR_W-1:0] a);
        return a[LANE_W-1:0];
    endfunction
endpackage

// File: rtl/wbuf_entries.sv
module wbuf_entries
    import wbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    input  logic              lock_head,
    input  logic              pop,
    input  logic [BLK_W-1:0]  probe_blk,
    output logic              probe_hit,
    output wb_entry_t         head_ent,
    output logic [CNT_W-1:0]  occ
);
    wb_entry_t         slot [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [DEPTH-1:0]  merge_vec, probe_vec;
    logic [PTR_W-1:0]  merge_idx;
    logic              merge_hit, accept, alloc;
    logic [BLK_W-1:0]  st_blk;
    logic [LANE_W-1:0] st_lane;
    wb_entry_t         fresh;

    assign st_blk  = blk_of(st_addr);
    assign st_lane = lane_of(st_addr);

    // One comparator pair per entry: merge target and read overlap
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic at_head;
        assign at_head      = lock_head && (head_q == PTR_W'(g));
        assign merge_vec[g] = slot[g].live && (slot[g].blk == st_blk) && !at_head;
        assign probe_vec[g] = slot[g].live && (slot[g].blk == probe_blk);
    end

    always_comb begin
        merge_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (merge_vec[i]) merge_idx = PTR_W'(i);
        end
    end

    assign merge_hit = |merge_vec;
    assign probe_hit = |probe_vec;
    assign st_ready  = merge_hit || (occ != CNT_W'(DEPTH));
    assign accept    = st_valid && st_ready;
    assign alloc     = accept && !merge_hit;
    assign head_ent  = slot[head_q];

    always_comb begin
        fresh               = '0;
        fresh.live          = 1'b1;
        fresh.blk           = st_blk;
        fresh.mask[st_lane] = 1'b1;
        fresh.data[st_lane] = st_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
            head_q <= '0;
            tail_q <= '0;
            occ    <= '0;
        end else begin
            if (pop) begin
                slot[head_q].live <= 1'b0;
                head_q            <= head_q + 1'b1;
            end
            if (accept) begin
                if (merge_hit) begin
                    slot[merge_idx].mask[st_lane] <= 1'b1;
                    slot[merge_idx].data[st_lane] <= st_data;
                end else begin
                    slot[tail_q] <= fresh;
                    tail_q       <= tail_q + 1'b1;
                end
            end
            occ <= occ + CNT_W'(alloc) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb
    import wbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_pend,
    input  logic       rd_block,
    input  logic       buf_empty,
    input  logic       mem_ready,
    input  logic       mem_rvalid,
    output arb_state_t state,
    output logic       pop,
    output logic       rd_done
);
    arb_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ARB_IDLE: begin
                if (rd_pend && !rd_block) nxt = ARB_RD;
                else if (!buf_empty)      nxt = ARB_WR;
            end
            ARB_WR:    if (mem_ready)  nxt = ARB_IDLE;
            ARB_RD:    if (mem_ready)  nxt = ARB_RWAIT;
            ARB_RWAIT: if (mem_rvalid) nxt = ARB_IDLE;
            default:   nxt = ARB_IDLE;
        endcase
    end

    assign pop     = (state == ARB_WR) && mem_ready;
    assign rd_done = (state == ARB_RWAIT) && mem_rvalid;

    always_ff @(posedge clk) begin
        if (rst) state <= ARB_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
    import wbuf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    st_valid,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [DATA_W-1:0]       st_data,
    output logic                    st_ready,
    input  logic                    rd_req,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_rsp_valid,
    output logic [DATA_W-1:0]       rd_rsp_data,
    output logic                    mem_valid,
    output logic                    mem_write,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LANES*DATA_W-1:0] mem_wdata,
    output logic [LANES-1:0]        mem_wmask,
    input  logic                    mem_ready,
    input  logic                    mem_rvalid,
    input  logic [DATA_W-1:0]       mem_rdata
);
    arb_state_t        state;
    wb_entry_t         head_ent;
    logic [CNT_W-1:0]  occ;
    logic              pop, rd_done, probe_hit, rd_block, wr_sel;
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_addr_q;

    wbuf_entries u_ent (
        .clk       (clk),
        .rst       (rst),
        .st_valid  (st_valid),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_ready  (st_ready),
        .lock_head (state == ARB_WR),
        .pop       (pop),
        .probe_blk (blk_of(rd_addr_q)),
        .probe_hit (probe_hit),
        .head_ent  (head_ent),
        .occ       (occ)
    );

    // A store landing in the same cycle also blocks the read
    assign rd_block = probe_hit || (st_valid && (blk_of(st_addr) == blk_of(rd_addr_q)));

    wbuf_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .rd_pend    (rd_pend),
        .rd_block   (rd_block),
        .buf_empty  (occ == '0),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .state      (state),
        .pop        (pop),
        .rd_done    (rd_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend      <= 1'b0;
            rd_addr_q    <= '0;
            rd_rsp_valid <= 1'b0;
            rd_rsp_data  <= '0;
        end else begin
            if (rd_done)                rd_pend <= 1'b0;
            else if (rd_req && !rd_pend) begin
                rd_pend   <= 1'b1;
                rd_addr_q <= rd_addr;
            end
            rd_rsp_valid <= rd_done;
            if (rd_done) rd_rsp_data <= mem_rdata;
        end
    end

    assign wr_sel    = (state == ARB_WR) && head_ent.live;
    assign mem_valid = wr_sel || (state == ARB_RD);
    assign mem_write = wr_sel;
    assign mem_addr  = wr_sel ? {head_ent.blk, {LANE_W{1'b0}}} : rd_addr_q;
    assign mem_wdata = head_ent.data;
    assign mem_wmask = wr_sel ? head_ent.mask : '0;
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk
    import wbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              st_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_wmask,
    input logic              mem_rvalid,
    input logic              rd_rsp_valid,
    input logic [CNT_W-1:0]  occ
);
    a_r8_valid_held: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> mem_valid);

    a_r8_cmd_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_write)));

    a_r5_mask_nonempty: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write) |-> (mem_wmask != '0));

    a_r1_ready_with_space: assert property (@(posedge clk) disable iff (rst)
        (occ < CNT_W'(DEPTH)) |-> st_ready);

    a_r2_occ_bound: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    a_r9_rsp_after_rvalid: assert property (@(posedge clk) disable iff (rst)
        rd_rsp_valid |-> $past(mem_rvalid));

    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_rsp_valid |=> !rd_rsp_valid);
endmodule

bind merge_wbuf wbuf_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .st_ready     (st_ready),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_write    (mem_write),
    .mem_addr     (mem_addr),
    .mem_wmask    (mem_wmask),
    .mem_rvalid   (mem_rvalid),
    .rd_rsp_valid (rd_rsp_valid),
    .occ          (occ)
);

// File: tb/sim_merge_wbuf.sv
`timescale 1ns/1ps
module sim_merge_wbuf;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         st_valid = 1'b0;
    logic [11:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic         st_ready;
    logic         rd_req = 1'b0;
    logic [11:0]  rd_addr = '0;
    logic         rd_rsp_valid;
    logic [31:0]  rd_rsp_data;
    logic         mem_valid, mem_write;
    logic [11:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [3:0]   mem_wmask;
    logic         mem_go = 1'b1;
    logic         mem_rvalid = 1'b0;
    logic [31:0]  mem_rdata = '0;

    always #2.5 clk = ~clk;

    merge_wbuf u0 (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
        .mem_ready(mem_go), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int nchk = 0;
    int nerr = 0;
    int rsp_cnt = 0;
    logic [9:0]   q_blk  [$];
    logic [3:0]   q_mask [$];
    logic [127:0] q_data [$];
    logic [31:0]  q_rd   [$];
    bit           cmdlog [$];
    logic [31:0]  img    [int];
    bit           rsched = 1'b0;
    int           rcnt = 0;
    logic [11:0]  raddr = '0;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic push_wr(input logic [9:0] b, input logic [3:0] m,
                           input logic [31:0] d0, input logic [31:0] d1,
                           input logic [31:0] d2, input logic [31:0] d3);
        q_blk.push_back(b);
        q_mask.push_back(m);
        q_data.push_back({d3, d2, d1, d0});
    endtask

    // Memory model and scoreboard monitor, away from the rising edge
    always @(negedge clk) begin
        if (rd_rsp_valid) begin
            rsp_cnt++;
            if (q_rd.size() == 0) check(1'b0, "R9 unexpected read response", rd_rsp_data, 0);
            else begin
                logic [31:0] e;
                e = q_rd.pop_front();
                check(rd_rsp_data == e, "R7/R9 read data", rd_rsp_data, e);
            end
        end
        mem_rvalid = 1'b0;
        if (rsched) begin
            if (rcnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = img.exists(int'(raddr)) ? img[int'(raddr)] : 32'h0;
                rsched     = 1'b0;
            end else rcnt--;
        end
        if (mem_valid && mem_go) begin
            cmdlog.push_back(mem_write);
            if (mem_write) begin
                if (q_blk.size() == 0) check(1'b0, "R5 unexpected drain", {116'h0, mem_addr}, 0);
                else begin
                    logic [9:0]   eb;
                    logic [3:0]   em;
                    logic [127:0] ed;
                    eb = q_blk.pop_front();
                    em = q_mask.pop_front();
                    ed = q_data.pop_front();
                    check(mem_addr == {eb, 2'b00}, "R5 drain block address", mem_addr, {eb, 2'b00});
                    check(mem_wmask == em, "R5 drain lane mask", mem_wmask, em);
                    for (int i = 0; i < 4; i++) begin
                        if (em[i]) begin
                            check(mem_wdata[32*i +: 32] == ed[32*i +: 32], "R3 drain lane data",
                                  mem_wdata[32*i +: 32], ed[32*i +: 32]);
                        end
                    end
                end
                for (int i = 0; i < 4; i++) begin
                    if (mem_wmask[i]) img[int'({mem_addr[11:2], 2'(i)})] = mem_wdata[32*i +: 32];
                end
            end else begin
                rsched = 1'b1;
                rcnt   = 1;
                raddr  = mem_addr;
            end
        end
    end

    task automatic do_store(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #1;
        while (!st_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic rd_issue(input logic [11:0] a, input logic [31:0] e);
        @(negedge clk);
        q_rd.push_back(e);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic rd_wait(input int target);
        while (rsp_cnt < target) @(negedge clk);
    endtask

    task automatic settle();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (q_blk.size() == 0 && q_rd.size() == 0 && !mem_valid && !rsched) break;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check(st_ready == 1'b1, "R10 reset st_ready", st_ready, 1);
        check(mem_valid == 1'b0, "R10 reset mem_valid", mem_valid, 0);
        check(rd_rsp_valid == 1'b0, "R10 reset rd_rsp_valid", rd_rsp_valid, 0);

        // Plain stores, memory free-running (R1, R5)
        push_wr(10'h004, 4'b0001, 32'h1000_0010, 0, 0, 0);
        push_wr(10'h0C0, 4'b0001, 32'h1000_0300, 0, 0, 0);
        do_store(12'h010, 32'h1000_0010);
        do_store(12'h300, 32'h1000_0300);
        settle();

        // Merge behind a draining head; draining head refuses merges (R3, R4)
        mem_go = 1'b0;
        push_wr(10'h008, 4'b0001, 32'h1000_0020, 0, 0, 0);
        push_wr(10'h00D, 4'b1111, 32'h1000_0034, 32'h2000_0035, 32'h1000_0036, 32'h1000_0037);
        push_wr(10'h008, 4'b0010, 0, 32'h1000_0021, 0, 0);
        do_store(12'h020, 32'h1000_0020);
        repeat (2) @(negedge clk);
        do_store(12'h034, 32'h1000_0034);
        do_store(12'h035, 32'h1000_0035);
        do_store(12'h036, 32'h1000_0036);
        do_store(12'h037, 32'h1000_0037);
        do_store(12'h021, 32'h1000_0021);
        do_store(12'h035, 32'h2000_0035);
        mem_go = 1'b1;
        settle();
        check(q_blk.size() == 0, "R3 merged block drained once", q_blk.size(), 0);

        // Full buffer stall, merge still allowed (R1, R2, R4, R8)
        mem_go = 1'b0;
        push_wr(10'h010, 4'b0001, 32'h1000_0040, 0, 0, 0);
        push_wr(10'h011, 4'b0001, 32'h1000_0044, 0, 0, 0);
        push_wr(10'h012, 4'b0101, 32'h1000_0048, 0, 32'h1000_004A, 0);
        push_wr(10'h013, 4'b0001, 32'h1000_004C, 0, 0, 0);
        push_wr(10'h010, 4'b0010, 0, 32'h1000_0041, 0, 0);
        push_wr(10'h014, 4'b0001, 32'h1000_0050, 0, 0, 0);
        do_store(12'h040, 32'h1000_0040);
        repeat (2) @(negedge clk);
        do_store(12'h044, 32'h1000_0044);
        do_store(12'h048, 32'h1000_0048);
        do_store(12'h04C, 32'h1000_004C);
        @(negedge clk);
        st_valid = 1'b1; st_addr = 12'h050; st_data = 32'h1000_0050;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(st_ready == 1'b0, "R2 full buffer stalls new block", st_ready, 0);
            check(mem_valid == 1'b1 && mem_addr == 12'h040, "R8 stalled drain held", mem_addr, 12'h040);
            @(negedge clk);
        end
        st_addr = 12'h041; st_data = 32'h1000_0041;
        #1;
        check(st_ready == 1'b0, "R4 draining head not mergeable when full", st_ready, 0);
        st_addr = 12'h04A; st_data = 32'h1000_004A;
        #1;
        check(st_ready == 1'b1, "R1 merge accepted when full", st_ready, 1);
        @(negedge clk);
        st_valid = 1'b0;
        mem_go = 1'b1;
        do_store(12'h041, 32'h1000_0041);
        do_store(12'h050, 32'h1000_0050);
        settle();

        // Read bypasses pending drains when no conflict (R6)
        mem_go = 1'b0;
        push_wr(10'h020, 4'b0001, 32'h1000_0080, 0, 0, 0);
        push_wr(10'h021, 4'b0010, 0, 32'h1000_0085, 0, 0);
        do_store(12'h080, 32'h1000_0080);
        repeat (2) @(negedge clk);
        do_store(12'h085, 32'h1000_0085);
        rd_issue(12'h300, 32'h1000_0300);
        cmdlog.delete();
        mem_go = 1'b1;
        rd_wait(1);
        settle();
        check(cmdlog.size() == 3, "R6 command count", cmdlog.size(), 3);
        if (cmdlog.size() == 3) begin
            check(cmdlog[1] == 1'b0, "R6 read issued ahead of pending drain", cmdlog[1], 0);
            check(cmdlog[2] == 1'b1, "R6 pending drain after read", cmdlog[2], 1);
        end

        // Conflicting read waits for the overlapping entry (R7)
        mem_go = 1'b0;
        push_wr(10'h030, 4'b0001, 32'h1000_00C0, 0, 0, 0);
        push_wr(10'h031, 4'b0010, 0, 32'h3000_00C5, 0, 0);
        do_store(12'h0C0, 32'h1000_00C0);
        repeat (2) @(negedge clk);
        do_store(12'h0C5, 32'h3000_00C5);
        rd_issue(12'h0C5, 32'h3000_00C5);
        cmdlog.delete();
        mem_go = 1'b1;
        rd_wait(2);
        settle();
        check(cmdlog.size() == 3, "R7 command count", cmdlog.size(), 3);
        if (cmdlog.size() == 3) begin
            check(cmdlog[1] == 1'b1, "R7 overlapping entry drained first", cmdlog[1], 1);
            check(cmdlog[2] == 1'b0, "R7 read after overlap cleared", cmdlog[2], 0);
        end

        // Read with empty buffer; response pulse (R9)
        cmdlog.delete();
        rd_issue(12'h010, 32'h1000_0010);
        rd_wait(3);
        settle();
        check(cmdlog.size() == 1 && cmdlog[0] == 1'b0, "R9 single read command", cmdlog.size(), 1);
        check(q_blk.size() == 0 && q_rd.size() == 0, "R5 all expected traffic seen",
              q_blk.size() + q_rd.size(), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule